// File: doc/BRIEF.md
# MSI Termination Register Bank

This block terminates posted message-signalled interrupt writes. Each write carries a target address and a small data value. The address picks one leaf register out of a bank organised as groups. The data value picks the bit in that leaf register to set. Set bits stay pending until software reads the leaf register. That read returns the contents and clears them in the same access.

Each group also has a derived summary register. It shows which of the group's leaf registers hold any pending bit. Each group drives one level interrupt line, and the line stays high while the group's summary is nonzero. Software services a group as follows: it reads the summary, then reads each flagged leaf register, then reads the summary again until it comes back zero.

The defaults give 16 groups of 8 leaf registers with 16 bits each, for 2048 vectors in total. Leaf registers sit on a 64 KiB stride. Reads return data one cycle after the read is accepted.

Top module: `msi_term_bank`

## Requirements
- R1: After reset, every leaf register is empty, every interrupt output is low and rd_data is zero.
- R2: When wr_valid is high, wr_data is below 16 and wr_addr equals (g << 19) + (x << 16) with g in 0..15 and x in 0..7, the write ORs bit wr_data into leaf register x of group g. Bits already set are kept.
- R3: A write is dropped and changes no state in any of these cases: wr_data is 16 or more, wr_addr has any of bits 15:0 set, or wr_addr falls in the summary region (bit 23 set).
- R4: A read of a leaf-register address places that register's contents on rd_data in the cycle after rd_en, and clears the register.
- R5: The summary register of group g is at 0x800000 + (g << 16). Bit x reads 1 exactly when leaf register x of group g is nonzero, and bits above 7 read 0. Reading it changes no state.
- R6: irq_o[g] is high exactly while any leaf register of group g holds a pending bit.
- R7: If a write and a clearing read hit the same leaf register in the same cycle, the read returns the old contents and the written bit remains pending afterwards.
- R8: A read of an undecoded address returns zero and changes no state. This includes a summary-region address with any of bits 22:20 or 15:0 set.
- R9: A write to one leaf register leaves every other leaf register and every other group's interrupt unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | MSI write strobe |
| wr_addr | input | 24 | MSI target offset from bank base |
| wr_data | input | 32 | MSI data value (bit selector) |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 24 | Register read offset |
| rd_data | output | 32 | Read result, valid the cycle after rd_en |
| irq_o | output | 16 | Level interrupt, one per group |

## Verification
A leaf register that holds a stale or missing bit shows up on the group's interrupt line in the cycle after the write that should have changed it. It also appears in the summary read and in the leaf read one cycle after rd_en. A lost clear is visible as a second read of the same leaf register returning nonzero. A wrong decode is visible as a bit that lands in the wrong group's interrupt line, or as a dropped write that still raises a line. The same-cycle write and clear race is checked by reading the leaf register twice: the first read must return the old contents and the second must return only the new bit.

// File: rtl/msi_term_pkg.sv
package msi_term_pkg;
   typedef enum logic [1:0] {
      ACC_NONE = 2'd0,
      ACC_LEAF = 2'd1,
      ACC_SUM  = 2'd2
   } acc_kind_e;
endpackage

// File: rtl/msi_addr_decode.sv
module msi_addr_decode
   import msi_term_pkg::*;
#(
   parameter int ADDR_W      = 24,
   parameter int GRP_W       = 4,
   parameter int IDX_W       = 3,
   parameter int STRIDE_LOG2 = 16
) (
   input  logic [ADDR_W-1:0] addr_i,
   output acc_kind_e         kind_o,
   output logic [GRP_W-1:0]  grp_o,
   output logic [IDX_W-1:0]  idx_o
);
   localparam int SUM_BIT = STRIDE_LOG2 + IDX_W + GRP_W;
   localparam logic [ADDR_W-1:0] LOW_MASK  = ADDR_W'((64'd1 << STRIDE_LOG2) - 64'd1);
   localparam logic [ADDR_W-1:0] HIGH_MASK = ~ADDR_W'((64'd1 << (SUM_BIT + 1)) - 64'd1);
   localparam logic [ADDR_W-1:0] PAD_MASK  =
      ADDR_W'(((64'd1 << IDX_W) - 64'd1) << (STRIDE_LOG2 + GRP_W));

   if (SUM_BIT >= ADDR_W) begin : g_bad_addr_w
      $error("msi_addr_decode: ADDR_W too small for bank layout");
   end

   logic clean;
   assign clean = ((addr_i & LOW_MASK) == '0) && ((addr_i & HIGH_MASK) == '0);
   assign idx_o = addr_i[STRIDE_LOG2 +: IDX_W];

   always_comb begin
      kind_o = ACC_NONE;
      grp_o  = addr_i[STRIDE_LOG2 + IDX_W +: GRP_W];
      if (clean) begin
         if (!addr_i[SUM_BIT]) begin
            kind_o = ACC_LEAF;
         end else if ((addr_i & PAD_MASK) == '0) begin
            kind_o = ACC_SUM;
            grp_o  = addr_i[STRIDE_LOG2 +: GRP_W];
         end
      end
   end
endmodule

// File: rtl/msi_leaf_group.sv
module msi_leaf_group #(
   parameter int NUM_IDX = 8,
   parameter int VEC_W   = 16,
   localparam int IDX_W  = $clog2(NUM_IDX),
   localparam int BIT_W  = $clog2(VEC_W)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     set_i,
   input  logic [IDX_W-1:0]         set_idx,
   input  logic [BIT_W-1:0]         set_bit,
   input  logic                     clr_i,
   input  logic [IDX_W-1:0]         clr_idx,
   output logic [NUM_IDX*VEC_W-1:0] leaf_o,
   output logic [NUM_IDX-1:0]       summary_o,
   output logic                     irq_o
);
   logic [VEC_W-1:0] leaf_q [NUM_IDX];
   logic [VEC_W-1:0] set_mask;

   assign set_mask = VEC_W'(1) << set_bit;

   for (genvar x = 0; x < NUM_IDX; x++) begin : g_leaf
      logic set_hit, clr_hit;
      assign set_hit = set_i && (set_idx == IDX_W'(x));
      assign clr_hit = clr_i && (clr_idx == IDX_W'(x));

      always_ff @(posedge clk) begin
         if (!rst_n) leaf_q[x] <= '0;
         else        leaf_q[x] <= (clr_hit ? '0 : leaf_q[x]) | (set_hit ? set_mask : '0);
      end

      assign leaf_o[x*VEC_W +: VEC_W] = leaf_q[x];
      assign summary_o[x]             = |leaf_q[x];

      // R2: written bit is pending on the next cycle
      assert_bit_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
         (set_i && set_idx == IDX_W'(x)) |=> leaf_q[x][$past(set_bit)]);
      // R4: clearing read without a concurrent write empties the register
      assert_clear_on_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_i && clr_idx == IDX_W'(x) && !(set_i && set_idx == IDX_W'(x)))
         |=> (leaf_q[x] == '0));
      // R7: a write racing the clear leaves exactly its own bit
      assert_write_survives_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_i && clr_idx == IDX_W'(x) && set_i && set_idx == IDX_W'(x))
         |=> ($countones(leaf_q[x]) == 1));
      // R9: an untouched register keeps its value
      assert_untouched_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
         !((set_i && set_idx == IDX_W'(x)) || (clr_i && clr_idx == IDX_W'(x)))
         |=> $stable(leaf_q[x]));
   end

   assign irq_o = |summary_o;
endmodule

// File: rtl/msi_term_bank.sv
module msi_term_bank
   import msi_term_pkg::*;
#(
   parameter int NUM_GRP     = 16,
   parameter int NUM_IDX     = 8,
   parameter int VEC_W       = 16,
   parameter int STRIDE_LOG2 = 16,
   parameter int ADDR_W      = 24,
   parameter int DATA_W      = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_valid,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic [NUM_GRP-1:0] irq_o
);
   localparam int GRP_W = $clog2(NUM_GRP);
   localparam int IDX_W = $clog2(NUM_IDX);
   localparam int BIT_W = $clog2(VEC_W);

   if ((1 << GRP_W) != NUM_GRP || NUM_GRP < 2) begin : g_bad_grp
      $error("msi_term_bank: NUM_GRP must be a power of two >= 2");
   end
   if ((1 << IDX_W) != NUM_IDX || NUM_IDX < 2) begin : g_bad_idx
      $error("msi_term_bank: NUM_IDX must be a power of two >= 2");
   end
   if ((1 << BIT_W) != VEC_W || VEC_W < 2) begin : g_bad_vec
      $error("msi_term_bank: VEC_W must be a power of two >= 2");
   end
   if (DATA_W < VEC_W || DATA_W < NUM_IDX) begin : g_bad_data
      $error("msi_term_bank: DATA_W narrower than a register");
   end

   acc_kind_e        wkind, rkind;
   logic [GRP_W-1:0] wgrp, rgrp;
   logic [IDX_W-1:0] widx, ridx;

   msi_addr_decode #(.ADDR_W(ADDR_W), .GRP_W(GRP_W), .IDX_W(IDX_W),
                     .STRIDE_LOG2(STRIDE_LOG2)) u_wdec (
      .addr_i(wr_addr), .kind_o(wkind), .grp_o(wgrp), .idx_o(widx));

   msi_addr_decode #(.ADDR_W(ADDR_W), .GRP_W(GRP_W), .IDX_W(IDX_W),
                     .STRIDE_LOG2(STRIDE_LOG2)) u_rdec (
      .addr_i(rd_addr), .kind_o(rkind), .grp_o(rgrp), .idx_o(ridx));

   logic wr_ok, rd_clr;
   assign wr_ok  = wr_valid && (wkind == ACC_LEAF) && (wr_data < DATA_W'(VEC_W));
   assign rd_clr = rd_en && (rkind == ACC_LEAF);

   logic [NUM_IDX*VEC_W-1:0] leaf_all [NUM_GRP];
   logic [NUM_IDX-1:0]       sum_all  [NUM_GRP];

   for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
      msi_leaf_group #(.NUM_IDX(NUM_IDX), .VEC_W(VEC_W)) u_grp (
         .clk      (clk),
         .rst_n    (rst_n),
         .set_i    (wr_ok && (wgrp == GRP_W'(g))),
         .set_idx  (widx),
         .set_bit  (wr_data[BIT_W-1:0]),
         .clr_i    (rd_clr && (rgrp == GRP_W'(g))),
         .clr_idx  (ridx),
         .leaf_o   (leaf_all[g]),
         .summary_o(sum_all[g]),
         .irq_o    (irq_o[g])
      );
   end

   logic [VEC_W-1:0]   rd_leaf;
   logic [NUM_IDX-1:0] rd_sum;
   assign rd_leaf = leaf_all[rgrp][ridx*VEC_W +: VEC_W];
   assign rd_sum  = sum_all[rgrp];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_data <= '0;
      end else if (rd_en) begin
         case (rkind)
            ACC_LEAF: rd_data <= DATA_W'(rd_leaf);
            ACC_SUM:  rd_data <= DATA_W'(rd_sum);
            default:  rd_data <= '0;
         endcase
      end
   end

   // R3: a rejected write with no read leaves all lines unchanged
   assert_drop_bad_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && !rd_en && (wr_data >= DATA_W'(VEC_W) || wkind != ACC_LEAF))
      |=> $stable(irq_o));
   // R5: summary read has no side effect
   assert_summary_read_pure_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && rkind == ACC_SUM && !wr_valid) |=> $stable(irq_o));
   // R6: no access, no change on the interrupt lines
   assert_irq_idle_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_en && !wr_valid) |=> $stable(irq_o));
   // R8: undecoded read returns zero
   assert_undecoded_read_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && rkind == ACC_NONE) |=> (rd_data == '0));
   // R9: an accepted write raises at most the one addressed group line
   assert_single_group_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && !rd_en) |=> $countones(irq_o & ~$past(irq_o)) <= 1);
endmodule

// File: tb/msi_term_bank_tb.sv
`timescale 1ns/100ps
module msi_term_bank_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_valid = 1'b0;
   logic [23:0] wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic        rd_en = 1'b0;
   logic [23:0] rd_addr = '0;
   logic [31:0] rd_data;
   logic [15:0] irq_o;

   int total = 0;
   int bad   = 0;

   always #2.5 clk = ~clk;

   msi_term_bank u_dut (
      .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr),
      .rd_data(rd_data), .irq_o(irq_o));

   function automatic logic [23:0] leaf_a(int g, int x);
      return 24'((g << 19) | (x << 16));
   endfunction
   function automatic logic [23:0] sum_a(int g);
      return 24'(32'h800000 | (g << 16));
   endfunction

   typedef struct packed {
      logic        is_rd;
      logic [7:0]  req;
      logic [23:0] addr;
      logic [31:0] data;
      logic [31:0] exp;   // read: rd_data; write: irq_o after
   } vec_t;

   localparam int NV = 17;
   localparam vec_t TBL [NV] = '{
      '{1'b0, 8'd2, leaf_a(0,0),          32'd3,  32'h0001}, // R2
      '{1'b0, 8'd2, leaf_a(0,0),          32'd5,  32'h0001}, // R2 OR
      '{1'b0, 8'd9, leaf_a(5,7),          32'd15, 32'h0021}, // R9
      '{1'b0, 8'd6, leaf_a(15,2),         32'd0,  32'h8021}, // R6
      '{1'b1, 8'd5, sum_a(0),             32'd0,  32'h0001}, // R5
      '{1'b1, 8'd5, sum_a(5),             32'd0,  32'h0080}, // R5
      '{1'b1, 8'd4, leaf_a(0,0),          32'd0,  32'h0028}, // R4
      '{1'b1, 8'd4, leaf_a(0,0),          32'd0,  32'h0000}, // R4 cleared
      '{1'b1, 8'd5, sum_a(0),             32'd0,  32'h0000}, // R5
      '{1'b0, 8'd3, leaf_a(3,1),          32'd16, 32'h8020}, // R3 data
      '{1'b0, 8'd3, sum_a(3),             32'd1,  32'h8020}, // R3 summary
      '{1'b0, 8'd3, leaf_a(3,1) | 24'h4,  32'd1,  32'h8020}, // R3 low bits
      '{1'b1, 8'd4, leaf_a(5,7),          32'd0,  32'h8000}, // R4
      '{1'b1, 8'd4, leaf_a(15,2),         32'd0,  32'h0001}, // R4
      '{1'b0, 8'd6, leaf_a(1,1),          32'd0,  32'h0002}, // R6
      '{1'b1, 8'd8, 24'h900000,           32'd0,  32'h0000}, // R8
      '{1'b1, 8'd8, sum_a(1) | 24'h100,   32'd0,  32'h0000}  // R8
   };

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic do_write(logic [23:0] a, logic [31:0] d);
      wr_valid = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_valid = 1'b0;
   endtask

   task automatic do_read(logic [23:0] a, output logic [31:0] v);
      rd_en = 1'b1; rd_addr = a;
      @(negedge clk);
      v = rd_data;
      rd_en = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      check("R1 irq", 32'(irq_o), 32'h0);
      check("R1 rd_data", rd_data, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         if (TBL[i].is_rd) begin
            do_read(TBL[i].addr, v);
            check($sformatf("R%0d row%0d rd", TBL[i].req, i), v, TBL[i].exp);
         end else begin
            do_write(TBL[i].addr, TBL[i].data);
            check($sformatf("R%0d row%0d irq", TBL[i].req, i), 32'(irq_o), TBL[i].exp);
         end
      end

      // R7: write and clearing read to the same register in one cycle
      do_write(leaf_a(2,4), 32'd7);
      rd_en = 1'b1; rd_addr = leaf_a(2,4);
      wr_valid = 1'b1; wr_addr = leaf_a(2,4); wr_data = 32'd9;
      @(negedge clk);
      check("R7 old contents", rd_data, 32'h0080);
      rd_en = 1'b0; wr_valid = 1'b0;
      check("R7 irq stays", 32'(irq_o), 32'h0006);
      do_read(leaf_a(2,4), v);
      check("R7 new bit kept", v, 32'h0200);

      // R5: summary reads leave the leaf untouched
      do_read(sum_a(1), v);
      check("R5 first", v, 32'h0002);
      do_read(sum_a(1), v);
      check("R5 second", v, 32'h0002);
      do_read(leaf_a(1,1), v);
      check("R5 leaf intact", v, 32'h0001);
      check("R6 all clear", 32'(irq_o), 32'h0);

      // R1: reset in mid-run clears pending state
      do_write(leaf_a(7,0), 32'd1);
      check("R6 group7", 32'(irq_o), 32'h0080);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      check("R1 irq after reset", 32'(irq_o), 32'h0);
      do_read(leaf_a(7,0), v);
      check("R1 leaf after reset", v, 32'h0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule